// File: doc/BRIEF.md
# Code flow watchdog secure counter

This block checks that software walks through its code along the intended path. Software loads a signature counter and arms a countdown instruction timer. It then moves the counter with add and subtract writes placed along its path. At each checkpoint it writes the value the counter should hold at that point. If the counter differs, the timer runs out, commands arrive in an illegal order, the configuration is touched at the wrong moment, or an unmapped offset is accessed, the block records a fault. Each fault kind has its own sticky flag and its own configured response: none, an interrupt, or a reset request.

The block sits on a simple 32-bit word-addressed register bus. A request is a single-cycle strobe. Reads are combinational in the request cycle, and writes take effect at the clock edge that ends the request. The timer can be frozen while an interrupt is being serviced, or while a debugger halts the core. A plain persistent word lets software keep state across a fault-triggered reset.

Top module: `cflow_guard`

## Requirements
- R1: A write to offset 2 (START) while idle loads the signature counter with the written data and the instruction timer with the reload word (offset 5, reset value all ones), and makes the block active. The instruction timer can be read at offset 15.
- R2: While active and not frozen, the timer decrements once per cycle down to zero. At the first active cycle that begins with the timer at zero, flag bit 0 (timeout) is set and the block returns to idle. With reload value N, the flag therefore appears N+1 cycles after the START edge.
- R3: A write to offset 3 (STOP) while active compares the written data with the counter and returns the block to idle. If they differ, flag bit 1 (miscompare) is set.
- R4: A write to offset 4 (RESTART) while active makes the same compare and sets bit 1 on a mismatch. The block stays active and the timer is reloaded.
- R5: While active, a write to offset 6 adds the written data to the counter and offset 7 subtracts it. Offsets 8, 9 and 10 add 1, 16 and 256. Offsets 11, 12 and 13 subtract 1, 16 and 256. For these six fixed-step offsets the data is ignored.
- R6: Flag bit 2 (sequence) is set, and the command is otherwise ignored, on START while active, or on STOP, RESTART or any offset 6 to 13 while idle.
- R7: Any read or write to offsets 16 to 31 sets flag bit 4 (address) and reads as zero.
- R8: A write to CONTROL (offset 0) while active sets flag bit 3 (state) and is ignored. CONTROL reads as zero while active.
- R9: While idle and unlocked, a CONTROL write is rejected with flag bit 3 set in two cases: any 2-bit action field is 00, or bit 11 is 0. The action fields are bits [1:0] timeout, [3:2] miscompare, [5:4] sequence, [7:6] state and [9:8] address. The reset value of CONTROL is 0x955.
- R10: Setting CONTROL bit 13 locks the configuration. Later CONTROL writes while idle are ignored without a fault until reset.
- R11: FLAGS (offset 1) holds sticky bits [4:0], one per fault kind, plus bit 5, which is set by reset. Writing 1 to a bit clears it, and a new fault in the same cycle wins over the clear.
- R12: An action of 11 drives irq_o, 10 drives reset_req_o, and 01 does nothing. Each output is the OR over the set flags whose action selects it.
- R13: The timer holds its value while CONTROL bit 10 is set and irq_active_i is high, or while CONTROL bit 12 is set and dbg_halt_i is high.
- R14: Offset 14 is a read/write word that resets to zero and is not changed by any fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 5 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_active_i | input | 1 | An interrupt is being serviced |
| dbg_halt_i | input | 1 | Debugger halt is asserted |
| irq_o | output | 1 | Interrupt request |
| reset_req_o | output | 1 | Reset request |

## Verification
The hardest case to reach is the exact cycle at which the timer expires. The timer is visible only through a read, and the expiry also takes the block out of the active state. The stimulus loads a short reload value, reads the timer right after START, and then counts clock edges so that FLAGS is sampled once just before the expiry edge and once just after it. For the freeze paths, the stimulus holds the freeze input high across many cycles and reads back the unchanged timer. Every add and subtract offset is swept with several data values, each checked by one matching and one off-by-one STOP.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned NUM_FAULT = 5;
  localparam int unsigned F_TIMEOUT = 0;
  localparam int unsigned F_MISCMP  = 1;
  localparam int unsigned F_SEQ     = 2;
  localparam int unsigned F_STATE   = 3;
  localparam int unsigned F_ADDR    = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFF_CTRL    = 5'd0,
    OFF_FLAGS   = 5'd1,
    OFF_START   = 5'd2,
    OFF_STOP    = 5'd3,
    OFF_RESTART = 5'd4,
    OFF_RELOAD  = 5'd5,
    OFF_ADD     = 5'd6,
    OFF_SUB     = 5'd7,
    OFF_ADD1    = 5'd8,
    OFF_ADD16   = 5'd9,
    OFF_ADD256  = 5'd10,
    OFF_SUB1    = 5'd11,
    OFF_SUB16   = 5'd12,
    OFF_SUB256  = 5'd13,
    OFF_PERSIST = 5'd14,
    OFF_TIMER   = 5'd15
  } reg_off_e;

  localparam logic [1:0] ACT_ILLEGAL = 2'b00;
  localparam logic [1:0] ACT_NONE    = 2'b01;
  localparam logic [1:0] ACT_RESET   = 2'b10;
  localparam logic [1:0] ACT_IRQ     = 2'b11;

  typedef struct packed {
    logic [17:0]                 unused;
    logic                        lock;
    logic                        dbg_freeze;
    logic                        must_one;
    logic                        irq_freeze;
    logic [NUM_FAULT-1:0][1:0]   act;
  } ctrl_t;

  localparam logic [31:0] CTRL_RST = 32'h0000_0955;
endpackage

// File: rtl/cfw_sig_counter.sv
module cfw_sig_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         sub_i,
  input  logic [W-1:0] step_val_i,
  input  logic [W-1:0] cmp_val_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= sub_i ? cnt_q - step_val_i : cnt_q + step_val_i;
  end

  assign cnt_o   = cnt_q;
  assign match_o = (cnt_q == cmp_val_i);
endmodule

// File: rtl/cfw_instr_timer.sv
module cfw_instr_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic [W-1:0] timer_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (run_i && !at_zero) cnt_q <= cnt_q - 1'b1;
  end

  assign timer_o  = cnt_q;
  assign expire_o = run_i && at_zero && !load_i;
endmodule

// File: rtl/cfw_fault_unit.sv
module cfw_fault_unit #(
  parameter int unsigned NF = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NF-1:0]        event_i,
  input  logic                 clr_en_i,
  input  logic [NF:0]          clr_mask_i,
  input  logic [NF-1:0][1:0]   act_i,
  output logic [NF:0]          flags_o,
  output logic                 irq_o,
  output logic                 reset_req_o
);
  import cfw_pkg::*;

  logic [NF:0]   flags_q;
  logic [NF:0]   keep_mask;
  logic [NF-1:0] irq_hit;
  logic [NF-1:0] rst_hit;

  assign keep_mask = clr_en_i ? ~clr_mask_i : '1;

  // bit NF is the power-on marker; only software clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= {1'b1, {NF{1'b0}}};
    else         flags_q <= (flags_q & keep_mask) | {1'b0, event_i};
  end

  for (genvar i = 0; i < NF; i++) begin : g_act
    assign irq_hit[i] = flags_q[i] && (act_i[i] == ACT_IRQ);
    assign rst_hit[i] = flags_q[i] && (act_i[i] == ACT_RESET);
  end

  assign flags_o     = flags_q;
  assign irq_o       = |irq_hit;
  assign reset_req_o = |rst_hit;
endmodule

// File: rtl/cflow_guard.sv
module cflow_guard #(
  parameter int unsigned DATA_W     = 32,
  parameter logic [31:0] RELOAD_RST = 32'hFFFF_FFFF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [cfw_pkg::ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic                      irq_active_i,
  input  logic                      dbg_halt_i,
  output logic                      irq_o,
  output logic                      reset_req_o
);
  import cfw_pkg::*;

  localparam int unsigned NF = NUM_FAULT;

  logic              wr, acc;
  logic              active_q;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] reload_q, persist_q;
  logic [DATA_W-1:0] timer_q, cnt_q;
  logic [NF:0]       flags_q;
  logic              match, expire;

  logic wr_start, wr_stop, wr_restart, wr_ctrl, wr_flags;
  logic is_step_op, step_sub;
  logic [DATA_W-1:0] step_val;
  logic ctrl_bad, locked, frozen;
  logic [NF-1:0] ev;

  assign wr  = req_i && we_i;
  assign acc = req_i;

  assign wr_start   = wr && (addr_i == OFF_START);
  assign wr_stop    = wr && (addr_i == OFF_STOP);
  assign wr_restart = wr && (addr_i == OFF_RESTART);
  assign wr_ctrl    = wr && (addr_i == OFF_CTRL);
  assign wr_flags   = wr && (addr_i == OFF_FLAGS);

  // step decode: value and direction per offset
  always_comb begin
    is_step_op = wr;
    step_sub   = 1'b0;
    step_val   = '0;
    unique case (addr_i)
      OFF_ADD:    step_val = wdata_i;
      OFF_SUB:    begin step_val = wdata_i; step_sub = 1'b1; end
      OFF_ADD1:   step_val = DATA_W'(1);
      OFF_ADD16:  step_val = DATA_W'(16);
      OFF_ADD256: step_val = DATA_W'(256);
      OFF_SUB1:   begin step_val = DATA_W'(1);   step_sub = 1'b1; end
      OFF_SUB16:  begin step_val = DATA_W'(16);  step_sub = 1'b1; end
      OFF_SUB256: begin step_val = DATA_W'(256); step_sub = 1'b1; end
      default:    is_step_op = 1'b0;
    endcase
  end

  // control word legality
  always_comb begin
    ctrl_bad = !wdata_i[11];
    for (int i = 0; i < NF; i++)
      if (wdata_i[2*i +: 2] == ACT_ILLEGAL) ctrl_bad = 1'b1;
  end

  assign locked = ctrl_q.lock;
  assign frozen = (ctrl_q.irq_freeze && irq_active_i) ||
                  (ctrl_q.dbg_freeze && dbg_halt_i);

  assign ev[F_TIMEOUT] = expire;
  assign ev[F_MISCMP]  = active_q && (wr_stop || wr_restart) && !match;
  assign ev[F_SEQ]     = (wr_start && active_q) ||
                         (!active_q && (wr_stop || wr_restart || is_step_op));
  assign ev[F_STATE]   = wr_ctrl && (active_q || (!locked && ctrl_bad));
  assign ev[F_ADDR]    = acc && (addr_i > OFF_TIMER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    active_q <= 1'b0;
    else if (wr_start && !active_q) active_q <= 1'b1;
    else if (wr_stop && active_q)   active_q <= 1'b0;
    else if (expire)                active_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= ctrl_t'(CTRL_RST);
      reload_q  <= RELOAD_RST[DATA_W-1:0];
      persist_q <= '0;
    end else begin
      if (wr_ctrl && !active_q && !locked && !ctrl_bad)
        ctrl_q <= ctrl_t'({18'b0, wdata_i[13:0]});
      if (wr && addr_i == OFF_RELOAD)  reload_q  <= wdata_i;
      if (wr && addr_i == OFF_PERSIST) persist_q <= wdata_i;
    end
  end

  cfw_sig_counter #(.W(DATA_W)) u_sig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_start && !active_q),
    .load_val_i (wdata_i),
    .step_i     (is_step_op && active_q),
    .sub_i      (step_sub),
    .step_val_i (step_val),
    .cmp_val_i  (wdata_i),
    .cnt_o      (cnt_q),
    .match_o    (match)
  );

  cfw_instr_timer #(.W(DATA_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     ((wr_start && !active_q) || (wr_restart && active_q)),
    .load_val_i (reload_q),
    .run_i      (active_q && !frozen && !wr_stop),
    .timer_o    (timer_q),
    .expire_o   (expire)
  );

  cfw_fault_unit #(.NF(NF)) u_flt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .event_i     (ev),
    .clr_en_i    (wr_flags),
    .clr_mask_i  (wdata_i[NF:0]),
    .act_i       (ctrl_q.act),
    .flags_o     (flags_q),
    .irq_o       (irq_o),
    .reset_req_o (reset_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        OFF_CTRL:    rdata_o = active_q ? '0 : DATA_W'(ctrl_q);
        OFF_FLAGS:   rdata_o = DATA_W'(flags_q);
        OFF_RELOAD:  rdata_o = reload_q;
        OFF_PERSIST: rdata_o = persist_q;
        OFF_TIMER:   rdata_o = timer_q;
        default:     rdata_o = '0;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^{cnt_q, ctrl_q.unused, ctrl_q.must_one};
endmodule

// File: rtl/cfw_checker.sv
module cfw_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [4:0]        addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_active_i,
  input logic              reset_req_o,
  input logic              active_q,
  input logic [DATA_W-1:0] timer_q,
  input logic [DATA_W-1:0] reload_q,
  input logic [31:0]       ctrl_q,
  input logic [5:0]        flags_q
);
  assert_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && req_i && we_i && addr_i == 5'd2) |=> (active_q && timer_q == $past(reload_q)));

  assert_seq_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && req_i && we_i && addr_i == 5'd2) |=> flags_q[2]);

  assert_bad_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[4]) |=> flags_q[4]);

  assert_ctrl_hidden_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && req_i && !we_i && addr_i == 5'd0) |-> (rdata_o == '0));

  assert_flag_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == 5'd1) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_reset_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> (flags_q[4:0] != 5'b0));

  assert_irq_freeze_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && ctrl_q[10] && irq_active_i && !(req_i && we_i)) |=> (timer_q == $past(timer_q)));
endmodule

bind cflow_guard cfw_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .irq_active_i (irq_active_i),
  .reset_req_o  (reset_req_o),
  .active_q     (active_q),
  .timer_q      (timer_q),
  .reload_q     (reload_q),
  .ctrl_q       (32'(ctrl_q)),
  .flags_q      (flags_q)
);

// File: tb/cflow_guard_tb.sv
module cflow_guard_tb;
  localparam int A_CTRL = 0, A_FLAGS = 1, A_START = 2, A_STOP = 3, A_RESTART = 4,
                 A_RELOAD = 5, A_ADD = 6, A_PERSIST = 14, A_TIMER = 15;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_act = 0, dbg = 0;
  logic        irq, rst_req;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  cflow_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_active_i(irq_act), .dbg_halt_i(dbg),
    .irq_o(irq), .reset_req_o(rst_req)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    req = 1; we = 1; addr = 5'(a); wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    req = 1; we = 0; addr = 5'(a);
    #1 d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  function automatic logic [31:0] apply_op(input int op, input logic [31:0] v, input logic [31:0] d);
    case (op)
      0: return v + d;
      1: return v - d;
      2: return v + 1;
      3: return v + 16;
      4: return v + 256;
      5: return v - 1;
      6: return v - 16;
      default: return v - 256;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, expv;
    logic [31:0] vals [4];
    vals[0] = 32'h0; vals[1] = 32'h5; vals[2] = 32'hFFFF_FFF0; vals[3] = 32'h1234;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state, R9 reset control value
    rd(A_FLAGS, d); check("R11 por flag", d, 32'h20);
    rd(A_CTRL, d);  check("R9 ctrl reset", d, 32'h955);
    rd(A_PERSIST, d); check("R14 persist reset", d, 0);
    check("R12 irq reset", {31'b0, irq}, 0);
    check("R12 rstreq reset", {31'b0, rst_req}, 0);
    wr(A_FLAGS, 32'h3F);
    rd(A_FLAGS, d); check("R11 w1c clear", d, 0);

    // R14
    wr(A_PERSIST, 32'hCAFE_0001);
    rd(A_PERSIST, d); check("R14 persist rw", d, 32'hCAFE_0001);

    // R5 sweep with R1 load and R3 compare
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 4; k++) begin
        expv = apply_op(op, 32'h1000, vals[k]);
        wr(A_START, 32'h1000);
        wr(A_ADD + op, vals[k]);
        wr(A_STOP, expv);
        rd(A_FLAGS, d); check("R5 match stop", d, 0);
        wr(A_START, 32'h1000);
        wr(A_ADD + op, vals[k]);
        wr(A_STOP, expv + 1);
        rd(A_FLAGS, d); check("R3 mismatch stop", d, 32'h2);
        wr(A_FLAGS, 32'h3F);
      end
    end
    rd(A_CTRL, d); check("R3 idle after stop", d, 32'h955);
    rd(A_PERSIST, d); check("R14 persist kept", d, 32'hCAFE_0001);

    // R4 restart
    wr(A_RELOAD, 50);
    wr(A_START, 3);
    repeat (10) @(negedge clk);
    wr(A_RESTART, 3);
    rd(A_TIMER, d); check("R4 timer reloaded", d, 50);
    rd(A_CTRL, d);  check("R8 ctrl hidden active", d, 0);
    rd(A_FLAGS, d); check("R4 restart match", d, 0);
    wr(A_RESTART, 4);
    rd(A_FLAGS, d); check("R4 restart mismatch", d, 2);
    wr(A_STOP, 3);
    wr(A_FLAGS, 32'h3F);

    // R2 timeout timing
    wr(A_RELOAD, 5);
    wr(A_START, 0);
    rd(A_TIMER, d); check("R1 timer loaded", d, 5);
    repeat (4) @(negedge clk);
    rd(A_FLAGS, d); check("R2 no timeout yet", d, 0);
    rd(A_FLAGS, d); check("R2 timeout flag", d, 1);
    rd(A_CTRL, d);  check("R2 idle after timeout", d, 32'h955);
    wr(A_FLAGS, 32'h3F);

    // R13 freezes
    wr(A_CTRL, 32'hD55);
    wr(A_RELOAD, 3);
    irq_act = 1;
    wr(A_START, 0);
    repeat (10) @(negedge clk);
    rd(A_TIMER, d); check("R13 irq freeze", d, 3);
    rd(A_FLAGS, d); check("R13 no timeout frozen", d, 0);
    irq_act = 0;
    wr(A_STOP, 0);
    wr(A_CTRL, 32'h1955);
    dbg = 1;
    wr(A_START, 0);
    repeat (10) @(negedge clk);
    rd(A_TIMER, d); check("R13 dbg freeze", d, 3);
    dbg = 0;
    repeat (8) @(negedge clk);
    rd(A_FLAGS, d); check("R13 runs after release", d, 1);
    wr(A_FLAGS, 32'h3F);
    wr(A_CTRL, 32'h955);
    wr(A_RELOAD, 32'hFFFF);

    // R6 sequence faults
    wr(A_STOP, 0);
    rd(A_FLAGS, d); check("R6 stop idle", d, 4);
    rd(A_CTRL, d);  check("R6 still idle", d, 32'h955);
    wr(A_FLAGS, 32'h3F);
    wr(A_ADD + 2, 0);
    rd(A_FLAGS, d); check("R6 add idle", d, 4);
    wr(A_FLAGS, 32'h3F);
    wr(A_START, 7);
    wr(A_START, 100);
    rd(A_FLAGS, d); check("R6 start active", d, 4);
    wr(A_FLAGS, 32'h3F);
    wr(A_STOP, 7);
    rd(A_FLAGS, d); check("R6 counter kept", d, 0);

    // R7 address fault
    rd(20, d); check("R7 read zero", d, 0);
    rd(A_FLAGS, d); check("R7 addr flag", d, 32'h10);
    wr(A_FLAGS, 32'h3F);
    wr(31, 32'h1);
    rd(A_FLAGS, d); check("R7 write addr flag", d, 32'h10);
    wr(A_FLAGS, 32'h3F);

    // R8 ctrl write while active
    wr(A_START, 1);
    wr(A_CTRL, 32'hD55);
    rd(A_FLAGS, d); check("R8 state flag", d, 8);
    wr(A_STOP, 1);
    rd(A_CTRL, d); check("R8 ctrl unchanged", d, 32'h955);
    wr(A_FLAGS, 32'h3F);

    // R9 illegal control words
    wr(A_CTRL, 32'h954);
    rd(A_FLAGS, d); check("R9 action 00", d, 8);
    wr(A_FLAGS, 32'h3F);
    wr(A_CTRL, 32'h155);
    rd(A_FLAGS, d); check("R9 bit11 clear", d, 8);
    rd(A_CTRL, d);  check("R9 ctrl unchanged", d, 32'h955);
    wr(A_FLAGS, 32'h3F);

    // R12 actions
    wr(A_CTRL, 32'h975);
    wr(A_STOP, 0);
    check("R12 irq on seq", {31'b0, irq}, 1);
    check("R12 no rstreq", {31'b0, rst_req}, 0);
    wr(A_FLAGS, 32'h4);
    check("R12 irq cleared", {31'b0, irq}, 0);
    wr(A_CTRL, 32'h959);
    wr(A_START, 0);
    wr(A_STOP, 1);
    check("R12 rstreq on miscompare", {31'b0, rst_req}, 1);
    check("R12 no irq", {31'b0, irq}, 0);
    wr(A_FLAGS, 32'h3F);
    check("R12 rstreq cleared", {31'b0, rst_req}, 0);

    // R10 lock
    wr(A_CTRL, 32'h2955);
    wr(A_CTRL, 32'h0955);
    rd(A_CTRL, d);  check("R10 locked ctrl", d, 32'h2955);
    rd(A_FLAGS, d); check("R10 no fault", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule